// File: doc/BRIEF.md
# DMA Channel Request and Reload Controller

This block holds the control state of one DMA channel. It collects transfer requests from two kinds of trigger, holds them in a pending flag, and issues a one-cycle start pulse to a separate bus datapath when the channel is enabled. It also keeps the working address pointer and the remaining-transfer counter, and advances both each time the datapath reports a finished transfer.

A trigger comes either from software, by a write to the select register with its software-request bit high, or from one of a bank of peripheral interrupt-request lines. The line is picked by a select field plus a bank bit, and its rising edge counts as one request. Writing the enable bit high loads the working pointer and counter from their reload values, and does so again on every later enable write. The pending flag is set by any request, whether or not the channel is enabled. Software can clear the flag but cannot set it.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the pending flag, enable, start pulse, working pointer and working counter are all zero.
- R2: A control write with enable=1 loads the working pointer from `src_addr` when the source-forward bit of that write is 1. Otherwise it loads from `dst_addr` when the destination-forward bit is 1. With neither bit set it loads from `src_addr`.
- R3: A control write with enable=1 loads the working counter from `cnt_reload`, including when the channel is already enabled or a transfer is in flight.
- R4: A select write with `sel_swreq`=1 sets the pending flag one clock later, whether or not the channel is enabled.
- R5: A rising edge on the peripheral line with index {`sel_bank`,`sel_field`} (bank bit as MSB) as held in the select register sets the pending flag. A line held high gives one request only, and edges on unselected lines have no effect.
- R6: A select write that changes the field or the bank bit sets the pending flag.
- R7: A control write with `ctl_pend_wdata`=0 clears the pending flag. With `ctl_pend_wdata`=1 the flag is left unchanged, even when the same write sets enable=1.
- R8: When pending and enabled are both 1 and no transfer is in flight, `xfer_start` is high for exactly the next cycle, and the pending flag clears on that same edge. No start is issued while the channel is disabled.
- R9: Only one transfer is in flight at a time. No new start is issued between a start and the next `xfer_done`.
- R10: A `xfer_done` for a transfer in flight decrements the counter by 1. It increments the pointer by 1 when either direction bit is forward, and leaves it unchanged otherwise. A `xfer_done` with no transfer in flight is ignored.
- R11: When a completed transfer brings the counter to zero, the enable bit clears, unless a control write occurs in the same cycle.
- R12: A request in the same cycle as a software clear, or in the same cycle as a start, leaves the pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_enable | input | 1 | Enable bit value written |
| ctl_pend_wdata | input | 1 | Pending flag value written (0 clears, 1 ignored) |
| ctl_src_fwd | input | 1 | Source-forward direction bit written |
| ctl_dst_fwd | input | 1 | Destination-forward direction bit written |
| sel_we | input | 1 | Select register write strobe |
| sel_field | input | FIELD_W | Peripheral select field |
| sel_bank | input | 1 | Extra select (bank) bit |
| sel_swreq | input | 1 | Software request bit |
| src_addr | input | ADDR_W | Source address reload value |
| dst_addr | input | ADDR_W | Destination address reload value |
| cnt_reload | input | CNT_W | Transfer counter reload value |
| irq_lines | input | 2**(FIELD_W+1) | Peripheral interrupt-request lines |
| xfer_done | input | 1 | Datapath reports transfer finished |
| xfer_start | output | 1 | One-cycle start pulse to datapath |
| work_ptr | output | ADDR_W | Working forward address pointer |
| work_cnt | output | CNT_W | Working transfer counter |
| pending | output | 1 | Pending request flag |
| enabled | output | 1 | Channel enable bit |

## Verification
Two things can land on the pending flag in one cycle: a fresh request, and one of the two clears (a software write of 0, or the launch of a transfer). The bench provokes the first case with a software-request select write and a clearing control write in the same cycle. It provokes the second by issuing a software request in the cycle where a start is already due. In both cases the flag must read 1 afterwards. In the launch case the start pulse must still appear, and a second start must follow only after the datapath reports done.

// File: rtl/dma_chan_pkg.sv
// Package: shared types for the DMA channel controller.
// Assumes: nothing beyond IEEE 1800-2017.
package dma_chan_pkg;

    // Sequencer state: waiting to launch, or one transfer outstanding
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_t;

endpackage

// File: rtl/dma_trig_sel.sv
// Module: dma_trig_sel
// Holds the trigger select register and turns software requests, selected
// peripheral rising edges and select changes into a one-cycle request event.
// Assumes: irq_lines are synchronous to clk.
module dma_trig_sel #(
    parameter int FIELD_W = 4,
    localparam int SEL_W  = FIELD_W + 1,
    localparam int NLINES = 2 ** SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_we,
    input  logic [FIELD_W-1:0] sel_field,
    input  logic               sel_bank,
    input  logic               sel_swreq,
    input  logic [NLINES-1:0]  irq_lines,
    output logic               req_evt
);

    logic [SEL_W-1:0]  sel_idx_q;
    logic [SEL_W-1:0]  sel_idx_new;
    logic [NLINES-1:0] rise;
    logic              sel_chg;
    logic              sw_hit;

    assign sel_idx_new = {sel_bank, sel_field};

    // Select register: index of the peripheral line that triggers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx_q <= '0;
        end else if (sel_we) begin
            sel_idx_q <= sel_idx_new;
        end
    end

    // One rising-edge detector per peripheral line
    for (genvar g = 0; g < NLINES; g++) begin : g_edge
        logic prev_q;
        // Remember last level of this line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
            end else begin
                prev_q <= irq_lines[g];
            end
        end
        assign rise[g] = irq_lines[g] & ~prev_q;
    end

    // Combine the three request causes
    always_comb begin
        sel_chg = sel_we && (sel_idx_new != sel_idx_q);
        sw_hit  = sel_we && sel_swreq;
        req_evt = sw_hit | sel_chg | rise[sel_idx_q];
    end

endmodule

// File: rtl/dma_pend_flag.sv
// Module: dma_pend_flag
// Pending-request flag. Requests set it; software writes of 0 and transfer
// launch clear it; a set always wins over a clear in the same cycle.
// Assumes: software can never set the flag directly.
module dma_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic req_evt,
    input  logic sw_clr,
    input  logic launch_clr,
    output logic pending
);

    // Flag update with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (req_evt) begin
            pending <= 1'b1;
        end else if (sw_clr || launch_clr) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_seq.sv
// Module: dma_seq
// Launch sequencer: issues one registered start pulse when a request is
// pending on an enabled channel, then waits for done before relaunching.
// Assumes: the datapath raises xfer_done once per start.
module dma_seq
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic enabled,
    input  logic xfer_done,
    output logic launch,
    output logic done_ack,
    output logic xfer_start
);

    seq_state_t state_q;

    // Decide launch and done acceptance from current state
    always_comb begin
        launch   = (state_q == SEQ_IDLE) && pending && enabled;
        done_ack = (state_q == SEQ_BUSY) && xfer_done;
    end

    // State and start pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            xfer_start <= 1'b0;
        end else begin
            xfer_start <= launch;
            if (launch) begin
                state_q <= SEQ_BUSY;
            end else if (done_ack) begin
                state_q <= SEQ_IDLE;
            end
        end
    end

endmodule

// File: rtl/dma_work_regs.sv
// Module: dma_work_regs
// Enable bit, direction bits, working pointer and working counter.
// An enable write reloads pointer and counter; an accepted done steps them;
// reaching zero clears the enable. A control write beats a done.
// Assumes: done_ack only occurs with a transfer outstanding.
module dma_work_regs #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_enable,
    input  logic              ctl_src_fwd,
    input  logic              ctl_dst_fwd,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [CNT_W-1:0]  cnt_reload,
    input  logic              done_ack,
    output logic              enabled,
    output logic [ADDR_W-1:0] work_ptr,
    output logic [CNT_W-1:0]  work_cnt
);

    localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

    logic              src_fwd_q;
    logic              dst_fwd_q;
    logic [ADDR_W-1:0] reload_ptr;
    logic [CNT_W-1:0]  cnt_dec;

    // Pick the reload pointer from the direction bits being written
    always_comb begin
        if (ctl_src_fwd) begin
            reload_ptr = src_addr;
        end else if (ctl_dst_fwd) begin
            reload_ptr = dst_addr;
        end else begin
            reload_ptr = src_addr;
        end
        cnt_dec = work_cnt - CNT_ONE;
    end

    // Direction bits follow every control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_fwd_q <= 1'b0;
            dst_fwd_q <= 1'b0;
        end else if (ctl_we) begin
            src_fwd_q <= ctl_src_fwd;
            dst_fwd_q <= ctl_dst_fwd;
        end
    end

    // Enable, pointer and counter: reload on write, step on done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled  <= 1'b0;
            work_ptr <= '0;
            work_cnt <= '0;
        end else if (ctl_we) begin
            enabled <= ctl_enable;
            if (ctl_enable) begin
                work_ptr <= reload_ptr;
                work_cnt <= cnt_reload;
            end
        end else if (done_ack) begin
            work_cnt <= cnt_dec;
            if (src_fwd_q || dst_fwd_q) begin
                work_ptr <= work_ptr + PTR_ONE;
            end
            if (cnt_dec == '0) begin
                enabled <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_chan_ctrl.sv
// Module: dma_chan_ctrl (top)
// Request and reload control for one DMA channel: trigger selection,
// pending flag, launch sequencing and working pointer/counter upkeep.
// Assumes: register writes and irq lines are synchronous to clk.
module dma_chan_ctrl #(
    parameter int FIELD_W = 4,
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 8,
    localparam int NLINES = 2 ** (FIELD_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic               ctl_enable,
    input  logic               ctl_pend_wdata,
    input  logic               ctl_src_fwd,
    input  logic               ctl_dst_fwd,
    input  logic               sel_we,
    input  logic [FIELD_W-1:0] sel_field,
    input  logic               sel_bank,
    input  logic               sel_swreq,
    input  logic [ADDR_W-1:0]  src_addr,
    input  logic [ADDR_W-1:0]  dst_addr,
    input  logic [CNT_W-1:0]   cnt_reload,
    input  logic [NLINES-1:0]  irq_lines,
    input  logic               xfer_done,
    output logic               xfer_start,
    output logic [ADDR_W-1:0]  work_ptr,
    output logic [CNT_W-1:0]   work_cnt,
    output logic               pending,
    output logic               enabled
);

    logic req_evt;
    logic launch;
    logic done_ack;
    logic sw_clr;

    // Software clear: a control write carrying 0 in the pending bit
    assign sw_clr = ctl_we && !ctl_pend_wdata;

    dma_trig_sel #(.FIELD_W(FIELD_W)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_we    (sel_we),
        .sel_field (sel_field),
        .sel_bank  (sel_bank),
        .sel_swreq (sel_swreq),
        .irq_lines (irq_lines),
        .req_evt   (req_evt)
    );

    dma_pend_flag u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_evt    (req_evt),
        .sw_clr     (sw_clr),
        .launch_clr (launch),
        .pending    (pending)
    );

    dma_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .enabled    (enabled),
        .xfer_done  (xfer_done),
        .launch     (launch),
        .done_ack   (done_ack),
        .xfer_start (xfer_start)
    );

    dma_work_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_work (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_we      (ctl_we),
        .ctl_enable  (ctl_enable),
        .ctl_src_fwd (ctl_src_fwd),
        .ctl_dst_fwd (ctl_dst_fwd),
        .src_addr    (src_addr),
        .dst_addr    (dst_addr),
        .cnt_reload  (cnt_reload),
        .done_ack    (done_ack),
        .enabled     (enabled),
        .work_ptr    (work_ptr),
        .work_cnt    (work_cnt)
    );

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
// Module: dma_chan_ctrl_chk
// Property checker bound to dma_chan_ctrl. Tracks outstanding transfers on
// its own from start and done, independent of the design's sequencer.
module dma_chan_ctrl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic             ctl_enable,
    input logic             ctl_pend_wdata,
    input logic [CNT_W-1:0] cnt_reload,
    input logic             xfer_done,
    input logic             xfer_start,
    input logic             pending,
    input logic             enabled,
    input logic [CNT_W-1:0] work_cnt,
    input logic             req_evt
);

    logic outstanding;

    // Own model of whether a transfer is in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
        end else if (xfer_start) begin
            outstanding <= 1'b1;
        end else if (xfer_done) begin
            outstanding <= 1'b0;
        end
    end

    // R9
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !outstanding);

    // R8
    start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> $past(pending && enabled));

    // R8
    start_is_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R8
    start_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !$past(req_evt)) |-> !pending);

    // R3
    enable_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_enable) |=> (work_cnt == $past(cnt_reload)));

    // R7
    no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_pend_wdata && !pending && !req_evt) |=> !pending);

    // R4
    req_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_evt |=> pending);

    // R11
    zero_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding && xfer_done && work_cnt == CNT_W'(1) && !ctl_we) |=> !enabled);

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_we         (ctl_we),
    .ctl_enable     (ctl_enable),
    .ctl_pend_wdata (ctl_pend_wdata),
    .cnt_reload     (cnt_reload),
    .xfer_done      (xfer_done),
    .xfer_start     (xfer_start),
    .pending        (pending),
    .enabled        (enabled),
    .work_cnt       (work_cnt),
    .req_evt        (req_evt)
);

// File: tb/sim_dma_chan_ctrl.sv
`timescale 1ns/1ps
// Bench: scoreboard for dma_chan_ctrl. The driver pushes expected output
// snapshots after each clock edge; the monitor pops and compares them.
module sim_dma_chan_ctrl;

    localparam int FIELD_W = 4;
    localparam int ADDR_W  = 16;
    localparam int CNT_W   = 8;
    localparam int NLINES  = 2 ** (FIELD_W + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ctl_we = 1'b0;
    logic               ctl_enable = 1'b0;
    logic               ctl_pend_wdata = 1'b0;
    logic               ctl_src_fwd = 1'b0;
    logic               ctl_dst_fwd = 1'b0;
    logic               sel_we = 1'b0;
    logic [FIELD_W-1:0] sel_field = '0;
    logic               sel_bank = 1'b0;
    logic               sel_swreq = 1'b0;
    logic [ADDR_W-1:0]  src_addr = 16'h1000;
    logic [ADDR_W-1:0]  dst_addr = 16'h2000;
    logic [CNT_W-1:0]   cnt_reload = 8'd3;
    logic [NLINES-1:0]  irq_lines = '0;
    logic               xfer_done = 1'b0;
    logic               xfer_start;
    logic [ADDR_W-1:0]  work_ptr;
    logic [CNT_W-1:0]   work_cnt;
    logic               pending;
    logic               enabled;

    typedef struct {
        logic              p;
        logic              e;
        logic              s;
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  cnt;
        string             tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    dma_chan_ctrl #(.FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
        .ctl_pend_wdata(ctl_pend_wdata), .ctl_src_fwd(ctl_src_fwd),
        .ctl_dst_fwd(ctl_dst_fwd), .sel_we(sel_we), .sel_field(sel_field),
        .sel_bank(sel_bank), .sel_swreq(sel_swreq), .src_addr(src_addr),
        .dst_addr(dst_addr), .cnt_reload(cnt_reload), .irq_lines(irq_lines),
        .xfer_done(xfer_done), .xfer_start(xfer_start), .work_ptr(work_ptr),
        .work_cnt(work_cnt), .pending(pending), .enabled(enabled)
    );

    // Monitor: compare outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t x;
                x = exp_q.pop_front();
                checks++;
                if (pending !== x.p || enabled !== x.e || xfer_start !== x.s ||
                    work_ptr !== x.ptr || work_cnt !== x.cnt) begin
                    fails++;
                    $display("FAIL %s: got p=%0b e=%0b s=%0b ptr=%h cnt=%0d exp p=%0b e=%0b s=%0b ptr=%h cnt=%0d",
                             x.tag, pending, enabled, xfer_start, work_ptr, work_cnt,
                             x.p, x.e, x.s, x.ptr, x.cnt);
                end
            end
        end
    end

    // Driver helper: one clock edge, queue the expected result, drop strobes
    task automatic tick(input logic p, input logic e, input logic s,
                        input logic [ADDR_W-1:0] ptr, input logic [CNT_W-1:0] cnt,
                        input string tag);
        exp_t x;
        @(posedge clk);
        #1;
        x.p = p; x.e = e; x.s = s; x.ptr = ptr; x.cnt = cnt; x.tag = tag;
        exp_q.push_back(x);
        @(negedge clk);
        ctl_we    = 1'b0;
        sel_we    = 1'b0;
        sel_swreq = 1'b0;
        xfer_done = 1'b0;
    endtask

    task automatic ctl_wr(input logic en, input logic pw, input logic sf, input logic df);
        ctl_we = 1'b1; ctl_enable = en; ctl_pend_wdata = pw;
        ctl_src_fwd = sf; ctl_dst_fwd = df;
    endtask

    task automatic sel_wr(input logic [FIELD_W-1:0] f, input logic b, input logic sw);
        sel_we = 1'b1; sel_field = f; sel_bank = b; sel_swreq = sw;
    endtask

    // Watchdog
    initial begin
        #(4 * 5000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        tick(0, 0, 0, 16'h0000, 0, "R1 reset state");
        sel_wr(0, 0, 1);
        tick(1, 0, 0, 16'h0000, 0, "R4 sw request while disabled");
        tick(1, 0, 0, 16'h0000, 0, "R8 no start while disabled");
        ctl_wr(0, 0, 1, 0);
        tick(0, 0, 0, 16'h0000, 0, "R7 write 0 clears");
        ctl_wr(1, 1, 1, 0);
        tick(0, 1, 0, 16'h1000, 3, "R2 R3 R7 enable reload, pend 1 ignored");
        sel_wr(5, 1, 0);
        tick(1, 1, 0, 16'h1000, 3, "R6 select change sets pending");
        tick(0, 1, 1, 16'h1000, 3, "R8 start pulse clears pending");
        irq_lines[21] = 1'b1;
        tick(1, 1, 0, 16'h1000, 3, "R5 R9 selected rise while busy");
        xfer_done = 1'b1;
        tick(1, 1, 0, 16'h1001, 2, "R10 R9 step on done, no start yet");
        tick(0, 1, 1, 16'h1001, 2, "R8 second start");
        tick(0, 1, 0, 16'h1001, 2, "R5 held level no new request");
        xfer_done = 1'b1;
        tick(0, 1, 0, 16'h1002, 1, "R10 step on done");
        irq_lines[3] = 1'b1;
        tick(0, 1, 0, 16'h1002, 1, "R5 unselected line ignored");
        irq_lines[21] = 1'b0;
        tick(0, 1, 0, 16'h1002, 1, "R5 falling edge ignored");
        irq_lines[21] = 1'b1;
        tick(1, 1, 0, 16'h1002, 1, "R5 new rising edge");
        tick(0, 1, 1, 16'h1002, 1, "R8 third start");
        xfer_done = 1'b1;
        tick(0, 0, 0, 16'h1003, 0, "R11 counter zero disables");
        xfer_done = 1'b1;
        tick(0, 0, 0, 16'h1003, 0, "R10 done while idle ignored");
        sel_wr(5, 1, 1);
        ctl_wr(0, 0, 1, 0);
        tick(1, 0, 0, 16'h1003, 0, "R12 request beats software clear");
        cnt_reload = 8'd2;
        ctl_wr(1, 1, 0, 1);
        tick(1, 1, 0, 16'h2000, 2, "R2 reload from destination");
        tick(0, 1, 1, 16'h2000, 2, "R8 start after enable");
        dst_addr = 16'h2100;
        cnt_reload = 8'd5;
        ctl_wr(1, 1, 0, 1);
        tick(0, 1, 0, 16'h2100, 5, "R3 re-enable reloads again");
        xfer_done = 1'b1;
        tick(0, 1, 0, 16'h2101, 4, "R10 step after re-enable");
        sel_wr(5, 1, 1);
        tick(1, 1, 0, 16'h2101, 4, "R4 sw request while enabled");
        sel_wr(5, 1, 1);
        tick(1, 1, 1, 16'h2101, 4, "R12 request at start keeps pending");
        tick(1, 1, 0, 16'h2101, 4, "R9 no start while busy");
        xfer_done = 1'b1;
        tick(1, 1, 0, 16'h2102, 3, "R10 step");
        tick(0, 1, 1, 16'h2102, 3, "R8 start for held request");
        cnt_reload = 8'd1;
        ctl_wr(1, 1, 0, 0);
        tick(0, 1, 0, 16'h1000, 1, "R2 neither forward loads source");
        xfer_done = 1'b1;
        tick(0, 0, 0, 16'h1000, 0, "R10 R11 fixed pointer, zero disables");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule